// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a load/store processor in which each procedure level gets its own set of registers. Software always sees 32 registers, numbered 0 to 31, through two combinational read ports and one write port. Numbers 0 to 7 name a shared global bank that looks the same from every level. Numbers 8 to 31 name registers in the active window, which a 5-bit current window pointer selects.

A window has three groups of eight: outgoing arguments at 8–15, private locals at 16–23 and incoming arguments at 24–31. A save command moves the pointer down by one, modulo the window count. A restore command moves it up by one. The outgoing group of a window is the same physical storage as the incoming group of the window below it, so a caller places arguments in its outs and the callee finds them in its ins with no copy. Each window therefore adds sixteen physical registers of its own.

A mask register has one bit per window and marks the windows that are not resident. A save or restore that targets a marked window does not move the pointer. It raises a one-cycle trap so that handler software can spill or fill a window and update the mask.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, the trap output is low, the mask marks every window valid and every register reads zero.
- R2: Registers 1 to 7 are one shared bank, so a value written in one window reads back unchanged from any other window.
- R3: Register 0 always reads zero on both ports, and writes to it are ignored.
- R4: A save sets the pointer to (pointer − 1) mod NWIN and a restore sets it to (pointer + 1) mod NWIN, visible from the next cycle. When both are asserted together, the save is taken. With no command the pointer holds.
- R5: Registers 8–15 of window w are the same storage as registers 24–31 of window (w − 1) mod NWIN. Registers 16–23 are private to each window.
- R6: The mask is loaded from `wim_data_i` when `wim_we_i` is high and takes effect on the next cycle. Bit k set marks window k unavailable. A command whose target window is marked leaves the pointer unchanged, and `trap_o` is high in the following cycle only.
- R7: Reads are combinational. A read of the physical register being written in the same cycle returns the new data.
- R8: A write in the same cycle as a save or restore goes to the window that was active before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rs1_addr_i | input | 5 | Read port 1 register number |
| rs1_data_o | output | DW | Read port 1 data |
| rs2_addr_i | input | 5 | Read port 2 register number |
| rs2_data_o | output | DW | Read port 2 data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register number |
| wr_data_i | input | DW | Write data |
| save_i | input | 1 | Move to the next lower window |
| restore_i | input | 1 | Move to the next higher window |
| wim_we_i | input | 1 | Load the window mask |
| wim_data_i | input | NWIN | New window mask value, bit k for window k |
| cwp_o | output | 5 | Current window pointer |
| trap_o | output | 1 | One-cycle pulse for a refused window change |

## Verification
Several events can fall in the same cycle. A mask load can arrive together with a save, and a register write can arrive together with a window change. The bench loads a clearing mask in the same cycle as a save toward a marked window and expects a trap, which shows that the command was judged against the old mask. It also writes an out register while saving, then expects the value under the new window's in number, which shows that the write used the pre-change window.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int NUM_GLOBAL = 8;
  localparam int GRP_SIZE   = 8;
  localparam int WIN_UNIQUE = 2 * GRP_SIZE;
  localparam int CWP_W      = 5;
  localparam int IDX_W      = 5;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_SAVE    = 2'd1,
    CMD_RESTORE = 2'd2
  } win_cmd_e;
endpackage

// File: rtl/rwin_addr_map.sv
module rwin_addr_map
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int PA_W = 8
) (
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  phys_o
);
  int win, off, base;

  always_comb begin
    off  = int'(idx_i[2:0]);
    win  = int'(cwp_i);
    base = 0;
    if (idx_i < IDX_W'(NUM_GLOBAL)) begin
      base = off;
    end else if (idx_i < IDX_W'(NUM_GLOBAL + GRP_SIZE)) begin
      // outs live in the ins slot of the window below
      base = NUM_GLOBAL + ((win == 0) ? NWIN - 1 : win - 1) * WIN_UNIQUE + off;
    end else if (idx_i < IDX_W'(NUM_GLOBAL + 2 * GRP_SIZE)) begin
      base = NUM_GLOBAL + win * WIN_UNIQUE + GRP_SIZE + off;
    end else begin
      base = NUM_GLOBAL + win * WIN_UNIQUE + off;
    end
    phys_o = PA_W'(base);
  end
endmodule

// File: rtl/rwin_storage.sv
module rwin_storage #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PA_W  = 8,
  parameter int NRD   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [PA_W-1:0]           wa_i,
  input  logic [DW-1:0]             wd_i,
  input  logic [NRD-1:0][PA_W-1:0]  ra_i,
  output logic [NRD-1:0][DW-1:0]    rd_o
);
  logic [DW-1:0] mem_q [NPHYS];
  logic          wr_live;

  assign wr_live = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else if (wr_live) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (ra_i[p] == '0)                 rd_o[p] = '0;
      else if (wr_live && wa_i == ra_i[p]) rd_o[p] = wd_i;
      else                               rd_o[p] = mem_q[ra_i[p]];
    end
  end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             wim_we_i,
  input  logic [NWIN-1:0]  wim_data_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             trap_o
);
  win_cmd_e         cmd;
  logic [CWP_W-1:0] cwp_q, target;
  logic [NWIN-1:0]  wim_q;
  logic             blocked, trap_q;

  always_comb begin
    if (save_i)         cmd = CMD_SAVE;
    else if (restore_i) cmd = CMD_RESTORE;
    else                cmd = CMD_NONE;
  end

  always_comb begin
    unique case (cmd)
      CMD_SAVE:    target = (cwp_q == '0) ? CWP_W'(NWIN - 1) : cwp_q - 1'b1;
      CMD_RESTORE: target = (cwp_q == CWP_W'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
      default:     target = cwp_q;
    endcase
  end

  assign blocked = |(wim_q & (NWIN'(1) << target));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q  <= '0;
      wim_q  <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= (cmd != CMD_NONE) && blocked;
      if (cmd != CMD_NONE && !blocked) cwp_q <= target;
      if (wim_we_i) wim_q <= wim_data_i;
    end
  end

  assign cwp_o  = cwp_q;
  assign trap_o = trap_q;
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       rs1_addr_i,
  output logic [DW-1:0]    rs1_data_o,
  input  logic [4:0]       rs2_addr_i,
  output logic [DW-1:0]    rs2_data_o,
  input  logic             wr_en_i,
  input  logic [4:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             wim_we_i,
  input  logic [NWIN-1:0]  wim_data_i,
  output logic [4:0]       cwp_o,
  output logic             trap_o
);
  localparam int NPHYS = NUM_GLOBAL + NWIN * WIN_UNIQUE;
  localparam int PA_W  = $clog2(NPHYS);
  localparam int NPORT = 3;

  logic [CWP_W-1:0]            cwp;
  logic [NPORT-1:0][IDX_W-1:0] idx;
  logic [NPORT-1:0][PA_W-1:0]  phys;
  logic [1:0][DW-1:0]          rd;

  assign idx[0] = rs1_addr_i;
  assign idx[1] = rs2_addr_i;
  assign idx[2] = wr_addr_i;

  rwin_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk_i, .rst_ni, .save_i, .restore_i, .wim_we_i, .wim_data_i,
    .cwp_o(cwp), .trap_o
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rwin_addr_map #(.NWIN(NWIN), .PA_W(PA_W)) u_map (
      .cwp_i(cwp), .idx_i(idx[p]), .phys_o(phys[p])
    );
  end

  rwin_storage #(.DW(DW), .NPHYS(NPHYS), .PA_W(PA_W), .NRD(2)) u_store (
    .clk_i, .rst_ni,
    .we_i(wr_en_i), .wa_i(phys[2]), .wd_i(wr_data_i),
    .ra_i({phys[1], phys[0]}), .rd_o(rd)
  );

  assign rs1_data_o = rd[0];
  assign rs2_data_o = rd[1];
  assign cwp_o      = cwp;
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    rs1_addr_i,
  input logic [DW-1:0] rs1_data_o,
  input logic [4:0]    rs2_addr_i,
  input logic [DW-1:0] rs2_data_o,
  input logic          save_i,
  input logic          restore_i,
  input logic [4:0]    cwp_o,
  input logic          trap_o
);
  assert_x0_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_addr_i == 5'd0) |-> (rs1_data_o == '0 && (rs2_addr_i != 5'd0 || rs2_data_o == '0)));

  assert_cwp_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwp_o < 5'(NWIN));

  assert_save_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> (trap_o || cwp_o == (($past(cwp_o) == 5'd0) ? 5'(NWIN - 1) : $past(cwp_o) - 5'd1)));

  assert_restore_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i) |=>
      (trap_o || cwp_o == (($past(cwp_o) == 5'(NWIN - 1)) ? 5'd0 : $past(cwp_o) + 5'd1)));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && !restore_i) |=> ($stable(cwp_o) && !trap_o));

  assert_trap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i || restore_i) |=> (!trap_o || $stable(cwp_o)));
endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rs1_addr_i(rs1_addr_i), .rs1_data_o(rs1_data_o),
  .rs2_addr_i(rs2_addr_i), .rs2_data_o(rs2_data_o),
  .save_i(save_i), .restore_i(restore_i),
  .cwp_o(cwp_o), .trap_o(trap_o)
);

// File: tb/rwin_regfile_test.sv
module rwin_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;
  localparam int DW   = 32;
  localparam int K_RS1 = 0, K_RS2 = 1, K_CWP = 2, K_TRAP = 3;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [4:0]      rs1_addr, rs2_addr, wr_addr;
  logic [DW-1:0]   rs1_data, rs2_data, wr_data;
  logic            wr_en, save, restore, wim_we;
  logic [NWIN-1:0] wim_data;
  logic [4:0]      cwp;
  logic            trap;

  typedef struct {
    int          kind;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rwin_regfile #(.NWIN(NWIN), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rs1_addr_i(rs1_addr), .rs1_data_o(rs1_data),
    .rs2_addr_i(rs2_addr), .rs2_data_o(rs2_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .save_i(save), .restore_i(restore),
    .wim_we_i(wim_we), .wim_data_i(wim_data),
    .cwp_o(cwp), .trap_o(trap)
  );

  task automatic expect_v(int kind, logic [31:0] v, string tag);
    exp_t e;
    e.kind = kind; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
    save = 0; restore = 0; wr_en = 0; wim_we = 0;
    rs1_addr = 0; rs2_addr = 0; wr_addr = 0; wr_data = 0; wim_data = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  // monitor: compare queued expectations mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = q.pop_front();
        case (e.kind)
          K_RS1:   act = rs1_data;
          K_RS2:   act = rs2_data;
          K_CWP:   act = 32'(cwp);
          default: act = 32'(trap);
        endcase
        n_vec++;
        if (act !== e.val) begin
          n_bad++;
          $display("FAIL %s: kind %0d actual %h expected %h", e.tag, e.kind, act, e.val);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    save = 0; restore = 0; wr_en = 0; wim_we = 0;
    rs1_addr = 0; rs2_addr = 0; wr_addr = 0; wr_data = 0; wim_data = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;

    tick(); rs1_addr = 5; rs2_addr = 24;
    expect_v(K_CWP, 0, "R1 cwp"); expect_v(K_TRAP, 0, "R1 trap");
    expect_v(K_RS1, 0, "R1 reg"); expect_v(K_RS2, 0, "R1 reg");
    tick(); wr(3, 32'hA3A3_0003);
    tick(); rs1_addr = 3; expect_v(K_RS1, 32'hA3A3_0003, "R2 global");
            wr(4, 32'hB4B4_0004); rs2_addr = 4; expect_v(K_RS2, 32'hB4B4_0004, "R7 bypass");
    tick(); wr(0, 32'hFFFF_FFFF); rs1_addr = 0; expect_v(K_RS1, 0, "R3 x0 during write");
    tick(); rs1_addr = 0; expect_v(K_RS1, 0, "R3 x0");
            rs2_addr = 4; expect_v(K_RS2, 32'hB4B4_0004, "R7 stored");
    tick(); wr(16, 32'h1616_0000);
    tick(); wr(8, 32'h0808_0000);
    tick(); wr(24, 32'h2424_0000);
    tick(); save = 1; rs1_addr = 24; expect_v(K_RS1, 32'h2424_0000, "R7 comb read");
    tick(); expect_v(K_CWP, 7, "R4 save wrap"); expect_v(K_TRAP, 0, "R4 no trap");
            rs1_addr = 24; expect_v(K_RS1, 32'h0808_0000, "R5 outs become ins");
            rs2_addr = 16; expect_v(K_RS2, 0, "R5 private locals");
    tick(); rs1_addr = 3; expect_v(K_RS1, 32'hA3A3_0003, "R2 global other window");
            wr(24, 32'h7777_0000);
    tick(); restore = 1;
    tick(); expect_v(K_CWP, 0, "R4 restore");
            rs1_addr = 8;  expect_v(K_RS1, 32'h7777_0000, "R5 ins back to outs");
            rs2_addr = 16; expect_v(K_RS2, 32'h1616_0000, "R5 locals kept");
    tick(); rs1_addr = 24; expect_v(K_RS1, 32'h2424_0000, "R5 own ins"); restore = 1;
    tick(); expect_v(K_CWP, 1, "R4 restore step"); save = 1;
    tick(); expect_v(K_CWP, 0, "R4 save step"); wim_we = 1; wim_data = 8'h80;
    tick(); save = 1;
    tick(); expect_v(K_TRAP, 1, "R6 trap on invalid"); expect_v(K_CWP, 0, "R6 cwp held");
    tick(); expect_v(K_TRAP, 0, "R6 trap one cycle"); expect_v(K_CWP, 0, "R6 cwp held");
            save = 1; wim_we = 1; wim_data = 8'h00;
    tick(); expect_v(K_TRAP, 1, "R6 old mask used"); expect_v(K_CWP, 0, "R6 cwp held");
            save = 1;
    tick(); expect_v(K_CWP, 7, "R6 mask cleared"); expect_v(K_TRAP, 0, "R6 no trap");
            save = 1; wr(8, 32'h9999_0000);
    tick(); expect_v(K_CWP, 6, "R8 cwp");
            rs1_addr = 24; expect_v(K_RS1, 32'h9999_0000, "R8 write used old window");
            rs2_addr = 8;  expect_v(K_RS2, 0, "R8 new outs untouched");
            wim_we = 1; wim_data = 8'h80;
    tick(); restore = 1;
    tick(); expect_v(K_TRAP, 1, "R6 restore trap"); expect_v(K_CWP, 6, "R6 cwp held");
            save = 1; restore = 1;
    tick(); expect_v(K_CWP, 5, "R4 save priority"); expect_v(K_TRAP, 0, "R4 no trap");
    tick();
    @(negedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule